// File: doc/BRIEF.md
# Peripheral Register File with Access-Triggered Side Effects

This block sits between a simple single-master peripheral bus and a device core. On the bus side it decodes a byte address into a register row and completes reads and writes in one cycle. On the core side every stored bit is visible in parallel at all times. The core can load its status word in any cycle.

The block also watches each bus access and acts on it:
- A write to a software-driven row raises a one-cycle pulse toward the core, even when the value written is unchanged.
- A read of the event row clears the sticky event bits that single-cycle core events have set.
- A read of the receive head row pops one entry from a small FIFO that the core fills.

Accesses outside the mapped rows complete normally. They return zero and have no side effects.

The row map is fixed by behaviour. Row 0 is the control row and is read-write. Row 1 is the command row and is write-only. Row 2 is the core status row and is read-only. Row 3 is the event row, which clears on read. Row 4 is the receive head row, which pops on read. Row 5 is the receive fill-count row and is read-only. Rows 6 and 7 are not mapped.

Top module: `periph_regfile`

## Requirements
- R1: A byte address selects row `(addr - BASE_ADDR) / SCALE`, where SCALE is 1, 2 or 4. The low log2(SCALE) address bits are ignored. An address outside the eight-row window starting at BASE_ADDR selects nothing.
- R2: `bus_ready` is always 1, so every request is accepted in the cycle it is presented. Read data is registered: `bus_rvalid` is high, with `bus_rdata`, in exactly the cycle after an accepted read.
- R3: The control row (row 0) is read-write. Byte lane b is written only when `bus_be[b]` is 1. The stored value drives `core_ctrl` in the cycle after the write.
- R4: Every write to row 0 or row 1 raises `ctrl_wr_pulse` or `cmd_wr_pulse` for exactly one cycle after the write. This holds even when the data equals the stored value or no byte lane is enabled.
- R5: The command row (row 1) is write-only. Its value drives `core_cmd`, and bus reads of it return zero.
- R6: The status row (row 2) is read-only. It loads `core_stat_d` when `core_stat_we` is high. Bus writes to it change nothing and raise no pulse.
- R7: A one-cycle high on `core_evt[i]` sets bit i of the event row (row 3). The bit stays set until the event row is read, and the read returns the bits as they were before the clear.
- R8: An event that arrives in the same cycle as a read of the event row remains set after that read.
- R9: `core_rx_valid` pushes `core_rx_data` into a FIFO of depth FIFO_DEPTH. Pushes into a full FIFO are dropped, and `core_rx_full` reports the full state. Each read of row 4 returns the oldest entry and removes it. Row 5 reads the current entry count.
- R10: A read of row 4 while the FIFO is empty returns zero and leaves the count unchanged. It sets bit EVT_W of the event row as a sticky underflow flag, and that flag clears on an event-row read like the other event bits.
- R11: Accesses to unmapped rows (6, 7) or to addresses outside the window return zero on reads. They raise no pulse and alter no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd_en | input | 1 | Read request |
| bus_wr_en | input | 1 | Write request |
| bus_ready | output | 1 | Request accepted (constant 1) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte-lane enables for writes |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| core_ctrl | output | DATA_W | Control row contents |
| core_cmd | output | DATA_W | Command row contents |
| ctrl_wr_pulse | output | 1 | One-cycle pulse after a control-row write |
| cmd_wr_pulse | output | 1 | One-cycle pulse after a command-row write |
| core_stat_we | input | 1 | Status row load enable |
| core_stat_d | input | DATA_W | Status row load value |
| core_evt | input | EVT_W | Transient event inputs |
| core_rx_valid | input | 1 | Receive FIFO push |
| core_rx_data | input | DATA_W | Receive FIFO push data |
| core_rx_full | output | 1 | Receive FIFO is full |

## Verification
Every result of this block appears one clock edge after the access or core input that causes it:
- read data and its valid flag;
- the write pulses;
- the new control and command values;
- sticky event bits;
- FIFO pops and the count.

The bench drives each stimulus just after a falling edge. It samples one time unit after the next rising edge, which is the only cycle a pulse or a read word is present. It then samples once more an edge later to confirm the pulse has dropped. Effects that hold, such as the count, sticky bits and stored rows, are confirmed later by ordinary bus reads.

// File: rtl/periph_regfile_pkg.sv
package periph_regfile_pkg;

    localparam int ROW_BITS = 3;

    localparam logic [ROW_BITS-1:0] RG_CTRL = 3'd0;
    localparam logic [ROW_BITS-1:0] RG_CMD  = 3'd1;
    localparam logic [ROW_BITS-1:0] RG_STAT = 3'd2;
    localparam logic [ROW_BITS-1:0] RG_EVT  = 3'd3;
    localparam logic [ROW_BITS-1:0] RG_HEAD = 3'd4;
    localparam logic [ROW_BITS-1:0] RG_CNT  = 3'd5;

    typedef struct packed {
        logic                hit;
        logic [ROW_BITS-1:0] row;
    } dec_t;

    function automatic logic row_mapped(input logic [ROW_BITS-1:0] r);
        return r <= RG_CNT;
    endfunction

    function automatic int scale_shift(input int scale);
        return (scale == 4) ? 2 : (scale == 2) ? 1 : 0;
    endfunction

endpackage

// File: rtl/rf_decode.sv
module rf_decode
    import periph_regfile_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [15:0]     BASE_ADDR = 16'h0400,
    parameter int              SCALE     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int SHIFT   = scale_shift(SCALE);
    localparam int TOP_LSB = SHIFT + ROW_BITS;
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

    logic                in_win;
    logic [ROW_BITS-1:0] row;

    assign in_win  = addr[ADDR_W-1:TOP_LSB] == BASE_V[ADDR_W-1:TOP_LSB];
    assign row     = addr[TOP_LSB-1:SHIFT];
    assign dec.hit = in_win && row_mapped(row);
    assign dec.row = row;
endmodule

// File: rtl/rf_fifo.sv
module rf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = count == '0;
    assign full    = count == CNT_W'(DEPTH);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= inc(wr_ptr);
            if (do_pop)  rd_ptr <= inc(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/rf_sticky.sv
module rf_sticky #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (clr) q <= set;
        else          q <= q | set;
    end
endmodule

// File: rtl/periph_regfile.sv
module periph_regfile
    import periph_regfile_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 32,
    parameter logic [15:0] BASE_ADDR  = 16'h0400,
    parameter int          SCALE      = 4,
    parameter int          FIFO_DEPTH = 4,
    parameter int          EVT_W      = 8,
    localparam int         BE_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd_en,
    input  logic              bus_wr_en,
    output logic              bus_ready,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] core_ctrl,
    output logic [DATA_W-1:0] core_cmd,
    output logic              ctrl_wr_pulse,
    output logic              cmd_wr_pulse,
    input  logic              core_stat_we,
    input  logic [DATA_W-1:0] core_stat_d,
    input  logic [EVT_W-1:0]  core_evt,
    input  logic              core_rx_valid,
    input  logic [DATA_W-1:0] core_rx_data,
    output logic              core_rx_full
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    dec_t              dec;
    logic [DATA_W-1:0] ctrl_q, cmd_q, stat_q, rdata_d;
    logic              wr_ctrl, wr_cmd, rd_evt, rd_head;
    logic [DATA_W-1:0] rx_head;
    logic              rx_empty;
    logic [CNT_W-1:0]  rx_count;
    logic [EVT_W:0]    evt_q;
    logic [EVT_W:0]    evt_set;

    assign bus_ready = 1'b1;

    rf_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .SCALE(SCALE)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign wr_ctrl = bus_wr_en && dec.hit && dec.row == RG_CTRL;
    assign wr_cmd  = bus_wr_en && dec.hit && dec.row == RG_CMD;
    assign rd_evt  = bus_rd_en && dec.hit && dec.row == RG_EVT;
    assign rd_head = bus_rd_en && dec.hit && dec.row == RG_HEAD;

    // Byte-lane merge for the software-driven rows
    generate
        for (genvar b = 0; b < BE_W; b++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    ctrl_q[8*b +: 8] <= '0;
                    cmd_q[8*b +: 8]  <= '0;
                end else begin
                    if (wr_ctrl && bus_be[b]) ctrl_q[8*b +: 8] <= bus_wdata[8*b +: 8];
                    if (wr_cmd  && bus_be[b]) cmd_q[8*b +: 8]  <= bus_wdata[8*b +: 8];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q        <= '0;
            ctrl_wr_pulse <= 1'b0;
            cmd_wr_pulse  <= 1'b0;
        end else begin
            if (core_stat_we) stat_q <= core_stat_d;
            ctrl_wr_pulse <= wr_ctrl;
            cmd_wr_pulse  <= wr_cmd;
        end
    end

    assign core_ctrl = ctrl_q;
    assign core_cmd  = cmd_q;

    rf_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .push      (core_rx_valid),
        .push_data (core_rx_data),
        .pop       (rd_head),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (core_rx_full),
        .count     (rx_count)
    );

    assign evt_set = {rd_head && rx_empty, core_evt};

    rf_sticky #(.N(EVT_W + 1)) u_evt (
        .clk (clk),
        .rst (rst),
        .set (evt_set),
        .clr (rd_evt),
        .q   (evt_q)
    );

    always_comb begin
        rdata_d = '0;
        if (dec.hit) begin
            case (dec.row)
                RG_CTRL: rdata_d = ctrl_q;
                RG_STAT: rdata_d = stat_q;
                RG_EVT:  rdata_d[EVT_W:0] = evt_q;
                RG_HEAD: rdata_d = rx_empty ? '0 : rx_head;
                RG_CNT:  rdata_d[CNT_W-1:0] = rx_count;
                default: rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd_en;
            bus_rdata  <= bus_rd_en ? rdata_d : '0;
        end
    end
endmodule

// File: rtl/periph_regfile_chk.sv
module periph_regfile_chk
    import periph_regfile_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 32,
    parameter logic [15:0] BASE_ADDR  = 16'h0400,
    parameter int          SCALE      = 4,
    parameter int          FIFO_DEPTH = 4,
    localparam int         CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd_en,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              ctrl_wr_pulse,
    input logic              cmd_wr_pulse,
    input logic              core_rx_valid,
    input logic [CNT_W-1:0]  rx_count
);
    localparam int SHIFT   = scale_shift(SCALE);
    localparam int TOP_LSB = SHIFT + ROW_BITS;
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

    logic                win;
    logic [ROW_BITS-1:0] r;
    assign win = bus_addr[ADDR_W-1:TOP_LSB] == BASE_V[ADDR_W-1:TOP_LSB];
    assign r   = bus_addr[TOP_LSB-1:SHIFT];

    a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
        bus_rd_en |=> bus_rvalid);
    a_r2_no_stray_rvalid: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |=> !bus_rvalid);
    a_r4_ctrl_pulse: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && win && r == RG_CTRL) |=> ctrl_wr_pulse);
    a_r4_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr_pulse || cmd_wr_pulse) |-> $past(bus_wr_en));
    a_r5_cmd_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && win && r == RG_CMD) |=> bus_rdata == '0);
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CNT_W'(FIFO_DEPTH));
    a_r10_empty_read_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && win && r == RG_HEAD && rx_count == '0 && !core_rx_valid) |=> rx_count == '0);
    a_r11_unmapped_no_pulse: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && !(win && row_mapped(r))) |=> !(ctrl_wr_pulse || cmd_wr_pulse));
    a_r11_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && !(win && row_mapped(r))) |=> bus_rdata == '0);
endmodule

bind periph_regfile periph_regfile_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
    .SCALE(SCALE), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_rd_en     (bus_rd_en),
    .bus_wr_en     (bus_wr_en),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .ctrl_wr_pulse (ctrl_wr_pulse),
    .cmd_wr_pulse  (cmd_wr_pulse),
    .core_rx_valid (core_rx_valid),
    .rx_count      (rx_count)
);

// File: tb/periph_regfile_bench.sv
module periph_regfile_bench;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int EVT_W  = 8;
    localparam logic [15:0] BASE = 16'h0400;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_rd_en = 1'b0, bus_wr_en = 1'b0;
    logic              bus_ready;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [3:0]        bus_be = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_rvalid;
    logic [DATA_W-1:0] core_ctrl, core_cmd;
    logic              ctrl_wr_pulse, cmd_wr_pulse;
    logic              core_stat_we = 1'b0;
    logic [DATA_W-1:0] core_stat_d = '0;
    logic [EVT_W-1:0]  core_evt = '0;
    logic              core_rx_valid = 1'b0;
    logic [DATA_W-1:0] core_rx_data = '0;
    logic              core_rx_full;

    int n_checks = 0;
    int n_fail   = 0;
    logic p_ctrl, p_cmd, rv;
    logic [DATA_W-1:0] rd;

    always #2 clk = ~clk;

    periph_regfile u_periph_regfile (.*);

    function automatic logic [ADDR_W-1:0] ra(input int row);
        return BASE + ADDR_W'(row * 4);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk); #1;
        p_ctrl = ctrl_wr_pulse; p_cmd = cmd_wr_pulse;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_be = '0;
    endtask

    task automatic rdr(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        rd = bus_rdata; rv = bus_rvalid;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic pulses_dropped(input string req);
        @(posedge clk); #1;
        chk(!ctrl_wr_pulse && !cmd_wr_pulse, req, {ctrl_wr_pulse, cmd_wr_pulse}, 0);
    endtask

    task automatic t_reset;
        chk(core_ctrl == 0 && core_cmd == 0, "R3 reset", core_ctrl, 0);
        chk(!ctrl_wr_pulse && !cmd_wr_pulse && !bus_rvalid, "R2 reset", bus_rvalid, 0);
        chk(bus_ready, "R2 ready", bus_ready, 1);
        rdr(ra(5));
        chk(rv && rd == 0, "R9 reset count", rd, 0);
    endtask

    task automatic t_ctrl;
        wr(ra(0), 32'hA5A5_1234, 4'hF);
        chk(p_ctrl && !p_cmd, "R4 ctrl pulse", p_ctrl, 1);
        chk(core_ctrl == 32'hA5A5_1234, "R3 core_ctrl", core_ctrl, 32'hA5A5_1234);
        pulses_dropped("R4 one cycle");
        wr(ra(0), 32'hA5A5_1234, 4'hF);
        chk(p_ctrl, "R4 same value pulse", p_ctrl, 1);
        wr(ra(0), 32'hFFFF_0000, 4'b0100);
        chk(core_ctrl == 32'hA5FF_1234, "R3 byte enable", core_ctrl, 32'hA5FF_1234);
        wr(ra(0), 32'h0, 4'h0);
        chk(p_ctrl && core_ctrl == 32'hA5FF_1234, "R4 zero-lane pulse", core_ctrl, 32'hA5FF_1234);
        rdr(ra(0));
        chk(rv && rd == 32'hA5FF_1234, "R2 ctrl readback", rd, 32'hA5FF_1234);
    endtask

    task automatic t_cmd;
        wr(ra(1), 32'h0000_00C3, 4'hF);
        chk(p_cmd && !p_ctrl, "R4 cmd pulse", p_cmd, 1);
        chk(core_cmd == 32'hC3, "R5 core_cmd", core_cmd, 32'hC3);
        rdr(ra(1));
        chk(rv && rd == 0, "R5 write-only reads zero", rd, 0);
    endtask

    task automatic t_stat;
        @(negedge clk); core_stat_we = 1'b1; core_stat_d = 32'h0BAD_F00D;
        @(negedge clk); core_stat_we = 1'b0;
        wr(ra(2), 32'h1111_1111, 4'hF);
        chk(!p_ctrl && !p_cmd, "R6 write no pulse", {p_ctrl, p_cmd}, 0);
        rdr(ra(2));
        chk(rd == 32'h0BAD_F00D, "R6 read-only", rd, 32'h0BAD_F00D);
    endtask

    task automatic t_events;
        @(negedge clk); core_evt = 8'h05;
        @(negedge clk); core_evt = 8'h00;
        rdr(ra(3));
        chk(rd == 32'h05, "R7 sticky set", rd, 32'h05);
        rdr(ra(3));
        chk(rd == 32'h0, "R7 clear on read", rd, 0);
        @(negedge clk); core_evt = 8'h20;
        @(negedge clk); core_evt = 8'h00;
        @(negedge clk); bus_rd_en = 1'b1; bus_addr = ra(3); core_evt = 8'h80;
        @(posedge clk); #1; rd = bus_rdata;
        @(negedge clk); bus_rd_en = 1'b0; core_evt = 8'h00;
        chk(rd == 32'h20, "R8 read before clear", rd, 32'h20);
        rdr(ra(3));
        chk(rd == 32'h80, "R8 concurrent event kept", rd, 32'h80);
    endtask

    task automatic t_fifo;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); core_rx_valid = 1'b1; core_rx_data = 32'h100 + i;
        end
        @(negedge clk); core_rx_valid = 1'b0;
        #1 chk(core_rx_full, "R9 full", core_rx_full, 1);
        rdr(ra(5));
        chk(rd == 4, "R9 count at full", rd, 4);
        for (int i = 0; i < 4; i++) begin
            rdr(ra(4));
            chk(rd == 32'h100 + i, "R9 pop order", rd, 32'h100 + i);
        end
        rdr(ra(5));
        chk(rd == 0, "R9 drained", rd, 0);
    endtask

    task automatic t_underflow;
        rdr(ra(4));
        chk(rv && rd == 0, "R10 empty head zero", rd, 0);
        rdr(ra(5));
        chk(rd == 0, "R10 count unchanged", rd, 0);
        @(negedge clk); core_rx_valid = 1'b1; core_rx_data = 32'hBEEF;
        @(negedge clk); core_rx_valid = 1'b0;
        rdr(ra(4));
        chk(rd == 32'hBEEF, "R10 pointers not moved", rd, 32'hBEEF);
        rdr(ra(3));
        chk(rd == 32'h100, "R10 underflow flag", rd, 32'h100);
        rdr(ra(3));
        chk(rd == 0, "R10 flag cleared", rd, 0);
    endtask

    task automatic t_unmapped;
        wr(ra(6), 32'hDEAD_DEAD, 4'hF);
        chk(!p_ctrl && !p_cmd, "R11 unmapped no pulse", {p_ctrl, p_cmd}, 0);
        rdr(ra(7));
        chk(rv && rd == 0, "R11 unmapped reads zero", rd, 0);
        wr(16'h0800, 32'h7777_7777, 4'hF);
        chk(!p_ctrl && core_ctrl == 32'hA5FF_1234, "R11 outside window", core_ctrl, 32'hA5FF_1234);
        rdr(16'h0800);
        chk(rd == 0, "R11 outside reads zero", rd, 0);
    endtask

    task automatic t_scale;
        wr(BASE + 16'd3, 32'h0000_5A5A, 4'hF);
        chk(p_ctrl && core_ctrl == 32'h5A5A, "R1 low bits ignored", core_ctrl, 32'h5A5A);
        rdr(BASE + 16'd2);
        chk(rd == 32'h5A5A, "R1 row from scaled offset", rd, 32'h5A5A);
        wr(BASE + 16'd6, 32'h42, 4'hF);
        chk(p_cmd && core_cmd == 32'h42, "R1 row 1 at offset 4..7", core_cmd, 32'h42);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        t_reset;
        t_ctrl;
        t_cmd;
        t_stat;
        t_events;
        t_fifo;
        t_underflow;
        t_unmapped;
        t_scale;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule